// File: doc/BRIEF.md
# Dual-Channel Acquisition Sequencer

This block coordinates a two-channel sampling chain: two converters sampling the sum and difference signals, one buffer FIFO per converter, and a host processor that collects the results. A free-running sample clock comes in. The block hands out two gated copies of it. The encode copy drives both converters. The write copy drives both FIFO write ports. The host switches each copy with its own enable. The write copy is held back until the converters have produced enough encode pulses to fill their pipelines, so no stale words reach the FIFOs.

A capture ends when the reference FIFO's almost-full flag falls. On that falling edge the block stops both gated clocks and sends the host a one-cycle interrupt pulse. The host then drains each FIFO in turn. A select bit routes the host read strobe, qualified by the host chip-enable, to one FIFO as its read clock. The same bit routes that FIFO's low 14 bits onto the host data bus. Before the next capture the host requests a timed, low-going FIFO reset. The block does not re-arm until that reset has run to completion. The host can read the sequencer state on a two-bit port.

Top module: `acq_sequencer`

## Requirements
- R1: After reset: state_o is 0 (idle), enc_clk_o and wr_clk_o are low, irq_o is 0 and fifo_rst_n_o is 1.
- R2: While sampling, enc_clk_o follows clk in every cycle after the cycle in which enc_en_i was first registered high in the idle state.
- R3: While sampling, wr_clk_o stays low when wr_en_i is low. With both enables high from the start, exactly LAT (default 4) encode pulses come before the first write pulse.
- R4: A high-to-low transition of af_n_i seen while sampling gives exactly one irq_o pulse of one cycle, and state_o becomes 2 in the same cycle. After a completed FIFO reset the block arms again for the next capture.
- R5: Once the interrupt has fired, enc_clk_o and wr_clk_o stay low even while both enables remain high.
- R6: A falling af_n_i in the idle or readout state does not raise irq_o.
- R7: rd_clk_o[c] equals ce_i AND re_i for the channel c selected by chan_sel_i (0 = sum, 1 = difference). The other bit of rd_clk_o stays low.
- R8: host_data_o[13:0] carries bits 13..0 of the selected FIFO word, and host_data_o[31:14] is zero.
- R9: A one-cycle rst_req_i in the idle or readout state drives fifo_rst_n_o low for exactly RST_CYC (default 2) cycles, with state_o at 3. The block then returns to idle.
- R10: state_o uses the encoding 0 idle, 1 sampling, 2 awaiting readout, 3 resetting.
- R11: Dropping enc_en_i while sampling returns the block to idle and stops both gated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample and system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_en_i | input | 1 | Host enable for the converter encode clock |
| wr_en_i | input | 1 | Host enable for the FIFO write clock |
| af_n_i | input | 1 | Almost-full flag of the reference FIFO, active low |
| rst_req_i | input | 1 | Host request for a FIFO reset pulse |
| ce_i | input | 1 | Host chip-enable for the FIFO space, active high |
| re_i | input | 1 | Host read strobe, active high |
| chan_sel_i | input | 1 | Channel to read: 0 sum, 1 difference |
| fifo_sum_d_i | input | 18 | Output word of the sum FIFO |
| fifo_dif_d_i | input | 18 | Output word of the difference FIFO |
| enc_clk_o | output | 1 | Gated encode clock to both converters |
| wr_clk_o | output | 1 | Gated write clock to both FIFOs |
| irq_o | output | 1 | Capture-complete interrupt pulse |
| fifo_rst_n_o | output | 1 | FIFO reset, active low |
| rd_clk_o | output | 2 | Read clock per FIFO (bit 0 sum, bit 1 difference) |
| host_data_o | output | 32 | Host data bus |
| state_o | output | 2 | Sequencer state |

## Verification
The assertions assume that af_n_i and every host control input are synchronous to clk and change only away from its rising edge. They also assume that rst_req_i arrives only in the idle or readout state, and that chan_sel_i stays fixed while a read strobe is active. The bench drives every input on the falling clock edge. It issues the reset request only after the interrupt has fired or after sampling has been abandoned, and it changes the channel select only between table rows while the strobes are idle. Gated clock outputs are sampled during the high phase of clk, where an enabled clock must read 1.

// File: rtl/acq_pkg.sv
package acq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_READOUT = 2'd2,
        ST_RESET   = 2'd3
    } acq_state_e;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int LAT     = 4,
    parameter int RST_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enc_en_i,
    input  logic       wr_en_i,
    input  logic       af_n_i,
    input  logic       rst_req_i,
    output logic       enc_gate_o,
    output logic       wr_gate_o,
    output logic       irq_o,
    output logic       fifo_rst_n_o,
    output acq_state_e state_o
);
    localparam int LCW = $clog2(LAT + 1);
    localparam int RCW = $clog2(RST_CYC + 1);

    typedef struct packed {
        acq_state_e     st;
        logic           enc_gate;
        logic           wr_gate;
        logic [LCW-1:0] lat_cnt;
        logic [RCW-1:0] rst_cnt;
        logic           af_prev;
        logic           irq;
        logic           fifo_rst_n;
    } regs_t;

    regs_t r_d, r_q;
    logic  af_fall;

    always_comb begin
        r_d         = r_q;
        r_d.irq     = 1'b0;
        r_d.af_prev = af_n_i;
        af_fall     = r_q.af_prev & ~af_n_i;
        case (r_q.st)
            ST_IDLE: begin
                if (rst_req_i) begin
                    r_d.st      = ST_RESET;
                    r_d.rst_cnt = RCW'(RST_CYC - 1);
                end else if (enc_en_i) begin
                    r_d.st      = ST_SAMPLE;
                    r_d.lat_cnt = '0;
                end
            end
            ST_SAMPLE: begin
                if (af_fall) begin
                    r_d.st  = ST_READOUT;
                    r_d.irq = 1'b1;
                end else if (!enc_en_i) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.lat_cnt != LCW'(LAT)) begin
                    r_d.lat_cnt = r_q.lat_cnt + 1'b1;
                end
            end
            ST_READOUT: begin
                if (rst_req_i) begin
                    r_d.st      = ST_RESET;
                    r_d.rst_cnt = RCW'(RST_CYC - 1);
                end
            end
            default: begin
                if (r_q.rst_cnt == '0) r_d.st = ST_IDLE;
                else                   r_d.rst_cnt = r_q.rst_cnt - 1'b1;
            end
        endcase
        r_d.enc_gate   = (r_d.st == ST_SAMPLE);
        r_d.wr_gate    = (r_d.st == ST_SAMPLE) && (r_q.st == ST_SAMPLE) && wr_en_i
                         && (32'(r_q.lat_cnt) >= LAT - 1);
        r_d.fifo_rst_n = (r_d.st != ST_RESET);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st         <= ST_IDLE;
            r_q.enc_gate   <= 1'b0;
            r_q.wr_gate    <= 1'b0;
            r_q.lat_cnt    <= '0;
            r_q.rst_cnt    <= '0;
            r_q.af_prev    <= 1'b1;
            r_q.irq        <= 1'b0;
            r_q.fifo_rst_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign enc_gate_o   = r_q.enc_gate;
    assign wr_gate_o    = r_q.wr_gate;
    assign irq_o        = r_q.irq;
    assign fifo_rst_n_o = r_q.fifo_rst_n;
    assign state_o      = r_q.st;
endmodule

// File: rtl/acq_clk_gate.sv
module acq_clk_gate #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] gclk_o
);
    logic [N-1:0] en_lo_d, en_lo_q;

    always_comb en_lo_d = en_i;

    for (genvar i = 0; i < N; i++) begin : g_gate
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_lo_q[i] <= 1'b0;
            else        en_lo_q[i] <= en_lo_d[i];
        end
        assign gclk_o[i] = clk & en_lo_q[i];
    end
endmodule

// File: rtl/acq_rd_port.sv
module acq_rd_port #(
    parameter int NCH    = 2,
    parameter int FIFO_W = 18,
    parameter int DATA_W = 14,
    parameter int BUS_W  = 32
) (
    input  logic                         ce_i,
    input  logic                         re_i,
    input  logic [$clog2(NCH)-1:0]       sel_i,
    input  logic [NCH-1:0][FIFO_W-1:0]   fifo_d_i,
    output logic [NCH-1:0]               rd_clk_o,
    output logic [BUS_W-1:0]             bus_o
);
    logic strobe;
    assign strobe = ce_i & re_i;

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign rd_clk_o[c] = strobe && (32'(sel_i) == c);
    end

    always_comb begin
        bus_o               = '0;
        bus_o[DATA_W-1:0]   = fifo_d_i[sel_i][DATA_W-1:0];
    end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int LAT     = 4,
    parameter int RST_CYC = 2,
    parameter int FIFO_W  = 18,
    parameter int DATA_W  = 14,
    parameter int BUS_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_en_i,
    input  logic              wr_en_i,
    input  logic              af_n_i,
    input  logic              rst_req_i,
    input  logic              ce_i,
    input  logic              re_i,
    input  logic              chan_sel_i,
    input  logic [FIFO_W-1:0] fifo_sum_d_i,
    input  logic [FIFO_W-1:0] fifo_dif_d_i,
    output logic              enc_clk_o,
    output logic              wr_clk_o,
    output logic              irq_o,
    output logic              fifo_rst_n_o,
    output logic [1:0]        rd_clk_o,
    output logic [BUS_W-1:0]  host_data_o,
    output logic [1:0]        state_o
);
    logic       enc_gate, wr_gate;
    acq_state_e st;
    logic [1:0] gclk;

    acq_ctrl #(.LAT(LAT), .RST_CYC(RST_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .enc_en_i(enc_en_i), .wr_en_i(wr_en_i),
        .af_n_i(af_n_i), .rst_req_i(rst_req_i),
        .enc_gate_o(enc_gate), .wr_gate_o(wr_gate),
        .irq_o(irq_o), .fifo_rst_n_o(fifo_rst_n_o),
        .state_o(st)
    );

    acq_clk_gate #(.N(2)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .en_i({wr_gate, enc_gate}),
        .gclk_o(gclk)
    );

    acq_rd_port #(.NCH(2), .FIFO_W(FIFO_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_rd (
        .ce_i(ce_i), .re_i(re_i), .sel_i(chan_sel_i),
        .fifo_d_i({fifo_dif_d_i, fifo_sum_d_i}),
        .rd_clk_o(rd_clk_o),
        .bus_o(host_data_o)
    );

    assign enc_clk_o = gclk[0];
    assign wr_clk_o  = gclk[1];
    assign state_o   = st;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
    parameter int DATA_W = 14,
    parameter int BUS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       state_o,
    input logic             irq_o,
    input logic             enc_gate,
    input logic             wr_gate,
    input logic             fifo_rst_n_o,
    input logic [1:0]       rd_clk_o,
    input logic [BUS_W-1:0] host_data_o
);
    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_irq_enters_readout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (state_o == 2'd2) && $past(state_o) == 2'd1);
    p_readout_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> !enc_gate && !wr_gate);
    p_write_needs_encode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate |-> enc_gate);
    p_irq_only_from_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(state_o) == 2'd1);
    p_read_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_clk_o));
    p_reset_pulse_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rst_n_o |-> state_o == 2'd3);
    p_upper_bus_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_o[BUS_W-1:DATA_W] == '0);
endmodule

bind acq_sequencer acq_sequencer_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_o(state_o), .irq_o(irq_o),
    .enc_gate(enc_gate), .wr_gate(wr_gate), .fifo_rst_n_o(fifo_rst_n_o),
    .rd_clk_o(rd_clk_o), .host_data_o(host_data_o)
);

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int RST_CYC    = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enc_en = 0, wr_en = 0, af_n = 1, rst_req = 0, ce = 0, re = 0, sel = 0;
    logic [17:0] d_sum = '0, d_dif = '0;
    logic enc_clk, wr_clk, irq, fifo_rst_n;
    logic [1:0]  rd_clk, state;
    logic [31:0] bus;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_sequencer #(.LAT(LAT), .RST_CYC(RST_CYC)) u_acq_sequencer (
        .clk(clk), .rst_n(rst_n), .enc_en_i(enc_en), .wr_en_i(wr_en),
        .af_n_i(af_n), .rst_req_i(rst_req), .ce_i(ce), .re_i(re),
        .chan_sel_i(sel), .fifo_sum_d_i(d_sum), .fifo_dif_d_i(d_dif),
        .enc_clk_o(enc_clk), .wr_clk_o(wr_clk), .irq_o(irq),
        .fifo_rst_n_o(fifo_rst_n), .rd_clk_o(rd_clk), .host_data_o(bus),
        .state_o(state)
    );

    typedef struct packed {
        logic        ce, re, sel;
        logic [17:0] d0, d1;
        logic [1:0]  exp_rd;
        logic [31:0] exp_bus;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 1'b0, 18'h3FFFF, 18'h00000, 2'b01, 32'h3FFF},
        '{1'b1, 1'b1, 1'b1, 18'h12345, 18'h2ABCD, 2'b10, 32'h2BCD},
        '{1'b0, 1'b1, 1'b0, 18'h12345, 18'h2ABCD, 2'b00, 32'h2345},
        '{1'b1, 1'b0, 1'b1, 18'h00001, 18'h3C000, 2'b00, 32'h0000},
        '{1'b0, 1'b0, 1'b1, 18'h00001, 18'h01F0F, 2'b00, 32'h1F0F},
        '{1'b1, 1'b1, 1'b0, 18'h20001, 18'h3FFFF, 2'b01, 32'h0001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        tick();
        chk("R1 state", 32'(state), 32'd0);
        chk("R1 enc_clk", 32'(enc_clk), 32'd0);
        chk("R1 wr_clk", 32'(wr_clk), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 fifo_rst_n", 32'(fifo_rst_n), 32'd1);

        // R7 / R8 read path table
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ce = VECS[i].ce; re = VECS[i].re; sel = VECS[i].sel;
            d_sum = VECS[i].d0; d_dif = VECS[i].d1;
            #1;
            chk($sformatf("R7 rd_clk row%0d", i), 32'(rd_clk), 32'(VECS[i].exp_rd));
            chk($sformatf("R8 bus row%0d", i), bus, VECS[i].exp_bus);
        end
        @(negedge clk) begin ce = 0; re = 0; end

        // R2, R3: encode only, write held off by wr_en low
        @(negedge clk) begin enc_en = 1; wr_en = 0; end
        cnt = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (enc_clk) cnt++;
            if (wr_clk) cnt += 100;
        end
        chk("R2 encode pulses", 32'(cnt), 32'd11);
        chk("R10 sampling code", 32'(state), 32'd1);

        // R11 abort
        @(negedge clk) enc_en = 0;
        tick();
        tick();
        chk("R11 state idle", 32'(state), 32'd0);
        chk("R11 enc stopped", 32'(enc_clk), 32'd0);

        // R3 latency
        @(negedge clk) begin enc_en = 1; wr_en = 1; end
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (wr_clk) break;
            if (enc_clk) cnt++;
        end
        chk("R3 encode pulses before first write", 32'(cnt), 32'(LAT));
        chk("R3 write running", 32'(wr_clk), 32'd1);

        // R4 interrupt
        @(negedge clk) af_n = 0;
        tick();
        chk("R4 irq pulse", 32'(irq), 32'd1);
        chk("R4 readout state", 32'(state), 32'd2);
        tick();
        chk("R4 irq single", 32'(irq), 32'd0);
        tick();
        chk("R5 enc stopped", 32'(enc_clk), 32'd0);
        chk("R5 wr stopped", 32'(wr_clk), 32'd0);

        // R6 fall in readout ignored
        @(negedge clk) af_n = 1;
        tick();
        @(negedge clk) af_n = 0;
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (irq) cnt++;
        end
        chk("R6 no irq in readout", 32'(cnt), 32'd0);
        chk("R6 still readout", 32'(state), 32'd2);

        // R9 reset pulse
        @(negedge clk) begin enc_en = 0; wr_en = 0; rst_req = 1; end
        tick();
        chk("R9 resetting code", 32'(state), 32'd3);
        cnt = fifo_rst_n ? 0 : 1;
        @(negedge clk) rst_req = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (!fifo_rst_n) cnt++;
        end
        chk("R9 low cycles", 32'(cnt), 32'(RST_CYC));
        chk("R9 back to idle", 32'(state), 32'd0);

        // R6 fall in idle ignored
        @(negedge clk) af_n = 1;
        tick();
        @(negedge clk) af_n = 0;
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (irq) cnt++;
        end
        chk("R6 no irq in idle", 32'(cnt), 32'd0);
        chk("R6 idle kept", 32'(state), 32'd0);

        // R4 re-armed capture
        @(negedge clk) begin af_n = 1; enc_en = 1; wr_en = 1; end
        repeat (3) tick();
        @(negedge clk) af_n = 0;
        tick();
        chk("R4 rearmed irq", 32'(irq), 32'd1);
        @(negedge clk) begin enc_en = 0; wr_en = 0; end
        tick();
        finish_run();
    end
endmodule